// File: doc/BRIEF.md
# Millisecond Periodic Watchdog Timer

This block is a free-running timer with a period set in whole milliseconds. A prescaler divides the system clock into one-millisecond steps. A 16-bit period input sets how many steps make one timeout. While the period is nonzero, the timer counts up to the period, signals a timeout, and starts again at once. It does not stop after a timeout.

Each timeout produces two outputs. The first is a single-cycle event meant for an interrupt aggregator. The second is a pulse of fixed length meant for an external pin. Software restarts the count through a self-clearing restart strobe. Hardware restarts it through a dedicated restart input. Either restart stops the pending timeout. A period of zero stops the timer completely.

Top module: `wdt_timer`

## Requirements
- R1: While `rstN` is low, and on the first cycle after it rises, `irqEvent` and `pinPulse` are 0.
- R2: While `period` is 0, no `irqEvent` is produced and no new `pinPulse` starts.
- R3: A restart is sampled on some clock edge E. With a nonzero period P, `irqEvent` is then high in the cycle that follows edge E + P×CLKS_PER_MS. It repeats every P×CLKS_PER_MS cycles after that, for as long as nothing restarts the count.
- R4: `irqEvent` is high for exactly one cycle, when CLKS_PER_MS > 1. It rises in the same cycle in which `pinPulse` rises.
- R5: Each `pinPulse` stays high for exactly PULSE_CYCLES (default 32) clock cycles, provided the period is not changed to 0 while it is high.
- R6: A one-cycle `swRestart` strobe clears both the prescaler and the millisecond count. The edge that samples the strobe is the restart edge E of R3.
- R7: `hwRestart` clears both the prescaler and the millisecond count on every edge that samples it high. The last such edge is the restart edge E of R3.
- R8: A restart that is sampled on the same edge at which a timeout would occur wins. No `irqEvent` is produced for that timeout.
- R9: An edge that sees a `period` value different from the one sampled on the previous edge is a restart edge.
- R10: A change of `period` from a nonzero value to 0 ends any `pinPulse` in progress. `pinPulse` is low from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| period | input | PERIOD_W (16) | Timeout period in milliseconds; 0 disables the timer |
| swRestart | input | 1 | One-cycle software restart strobe (self-clearing bit) |
| hwRestart | input | 1 | Hardware restart input, active high |
| irqEvent | output | 1 | Single-cycle timeout event for the interrupt logic |
| pinPulse | output | 1 | Stretched timeout pulse for an external pin |

## Verification
The pulse-width and single-cycle properties assume that one millisecond spans at least PULSE_CYCLES system clocks. Under that condition a new timeout cannot start while the previous pin pulse is still high. The bench therefore uses 40 clocks per millisecond, which keeps even a 1 ms period longer than the 32-cycle pulse. The restart strobe is driven for exactly one cycle, as a self-clearing register bit would be. Period changes happen only at falling edges and are held steady for whole periods. This keeps each restart edge well defined for the expected-event queue.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic clear;   // zero prescaler and millisecond count
    logic run;     // advance the count this cycle
  } wdtStrobe_t;
endpackage

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_pkg::*;
#(
  parameter int CLKS_PER_MS = 200000,
  parameter int PERIOD_W    = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  wdtStrobe_t          strobe,
  input  logic [PERIOD_W-1:0] period,
  output logic                expire
);
  localparam int PRE_W = (CLKS_PER_MS > 1) ? $clog2(CLKS_PER_MS) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLKS_PER_MS - 1);

  logic [PRE_W-1:0]    preCnt;
  logic [PERIOD_W-1:0] msCnt;
  logic                preWrap;
  logic                msLast;

  assign preWrap = (preCnt == PRE_LAST);
  assign msLast  = (msCnt == period - PERIOD_W'(1));
  assign expire  = preWrap && msLast;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
      msCnt  <= '0;
    end else if (strobe.clear) begin
      preCnt <= '0;
      msCnt  <= '0;
    end else if (strobe.run) begin
      if (preWrap) begin
        preCnt <= '0;
        msCnt  <= msLast ? '0 : msCnt + PERIOD_W'(1);
      end else begin
        preCnt <= preCnt + PRE_W'(1);
      end
    end
  end
endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
#(
  parameter int PERIOD_W     = 16,
  parameter int PULSE_CYCLES = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [PERIOD_W-1:0] period,
  input  logic                swRestart,
  input  logic                hwRestart,
  input  logic                expire,
  output wdtStrobe_t          strobe,
  output logic                irqEvent,
  output logic                pinPulse
);
  localparam int STR_W = $clog2(PULSE_CYCLES + 1);
  localparam logic [STR_W-1:0] STR_LOAD = STR_W'(PULSE_CYCLES - 1);

  logic [PERIOD_W-1:0] periodQ;
  logic [STR_W-1:0]    stretchCnt;
  logic                periodChanged;
  logic                enabled;
  logic                fire;
  logic                cancel;

  assign periodChanged = (period != periodQ);
  assign enabled       = (period != '0);
  assign strobe.clear  = swRestart || hwRestart || periodChanged || !enabled;
  assign strobe.run    = !strobe.clear;
  assign fire          = expire && strobe.run;
  assign cancel        = periodChanged && !enabled;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      periodQ    <= '0;
      irqEvent   <= 1'b0;
      pinPulse   <= 1'b0;
      stretchCnt <= '0;
    end else begin
      periodQ  <= period;
      irqEvent <= fire;
      if (cancel) begin
        pinPulse   <= 1'b0;
        stretchCnt <= '0;
      end else if (fire) begin
        pinPulse   <= 1'b1;
        stretchCnt <= STR_LOAD;
      end else if (stretchCnt != '0) begin
        stretchCnt <= stretchCnt - STR_W'(1);
      end else begin
        pinPulse <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
  import wdt_pkg::*;
#(
  parameter int CLKS_PER_MS  = 200000,
  parameter int PERIOD_W     = 16,
  parameter int PULSE_CYCLES = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [PERIOD_W-1:0] period,
  input  logic                swRestart,
  input  logic                hwRestart,
  output logic                irqEvent,
  output logic                pinPulse
);
  wdtStrobe_t strobe;
  logic       expire;

  wdt_ctrl #(.PERIOD_W(PERIOD_W), .PULSE_CYCLES(PULSE_CYCLES)) ctrl_i (
    .clk(clk), .rstN(rstN), .period(period),
    .swRestart(swRestart), .hwRestart(hwRestart),
    .expire(expire), .strobe(strobe),
    .irqEvent(irqEvent), .pinPulse(pinPulse)
  );

  wdt_datapath #(.CLKS_PER_MS(CLKS_PER_MS), .PERIOD_W(PERIOD_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .period(period), .expire(expire)
  );
endmodule

// File: rtl/wdt_timer_chk.sv
module wdt_timer_chk #(
  parameter int CLKS_PER_MS  = 200000,
  parameter int PERIOD_W     = 16,
  parameter int PULSE_CYCLES = 32
) (
  input logic                clk,
  input logic                rstN,
  input logic [PERIOD_W-1:0] period,
  input logic                swRestart,
  input logic                hwRestart,
  input logic                irqEvent,
  input logic                pinPulse
);
  localparam int RUN_W = $clog2(PULSE_CYCLES + 2) + 1;
  localparam bit WIDE_MS = (CLKS_PER_MS >= PULSE_CYCLES);

  logic [RUN_W-1:0] runLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) runLen <= '0;
    else if (pinPulse) runLen <= runLen + RUN_W'(1);
    else runLen <= '0;
  end

  assert_event_starts_pin_R4: assert property (@(posedge clk) disable iff (!rstN)
    irqEvent |-> pinPulse);

  assert_event_single_R4: assert property (@(posedge clk) disable iff (!rstN)
    (irqEvent && CLKS_PER_MS > 1) |=> !irqEvent);

  assert_zero_period_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    (period == '0) |=> !irqEvent);

  assert_sw_restart_blocks_R6: assert property (@(posedge clk) disable iff (!rstN)
    swRestart |=> !irqEvent);

  assert_hw_restart_blocks_R7: assert property (@(posedge clk) disable iff (!rstN)
    hwRestart |=> !irqEvent);

  assert_cancel_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    ((period == '0) && ($past(period) != '0)) |=> !pinPulse);

  assert_pulse_width_R5: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(pinPulse) && ($past(period) != '0) && WIDE_MS) |-> (runLen == RUN_W'(PULSE_CYCLES)));
endmodule

bind wdt_timer wdt_timer_chk #(
  .CLKS_PER_MS(CLKS_PER_MS), .PERIOD_W(PERIOD_W), .PULSE_CYCLES(PULSE_CYCLES)
) chk_i (
  .clk(clk), .rstN(rstN), .period(period), .swRestart(swRestart),
  .hwRestart(hwRestart), .irqEvent(irqEvent), .pinPulse(pinPulse)
);

// File: tb/wdt_timer_tb_top.sv
`timescale 1ns/1ps
module wdt_timer_tb_top;
  localparam int CPM   = 40;
  localparam int PW    = 16;
  localparam int PULSE = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [PW-1:0] period = '0;
  logic          swRestart = 1'b0;
  logic          hwRestart = 1'b0;
  logic          irqEvent;
  logic          pinPulse;

  always #2.5 clk = ~clk;

  wdt_timer #(.CLKS_PER_MS(CPM), .PERIOD_W(PW), .PULSE_CYCLES(PULSE)) dut_i (
    .clk(clk), .rstN(rstN), .period(period), .swRestart(swRestart),
    .hwRestart(hwRestart), .irqEvent(irqEvent), .pinPulse(pinPulse)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int  expQ[$];
  int  nTests = 0;
  int  nFail  = 0;
  int  evCount = 0;
  int  pinStarts = 0;
  int  runLen = 0;
  bit  prevPin = 1'b0;
  bit  pinCheckEn = 1'b1;
  bit  finished = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rstN) begin
      if (irqEvent) begin
        evCount++;
        if (expQ.size() == 0) begin
          check(1'b0, "R3", "unexpected irqEvent at cycle", cyc, -1);
        end else begin
          int e;
          e = expQ.pop_front();
          check(cyc == e, "R3", "irqEvent cycle", cyc, e);
        end
        check(pinPulse && !prevPin, "R4", "pinPulse rises with irqEvent",
              {prevPin, pinPulse}, 1);
      end
      if (pinPulse && !prevPin) pinStarts++;
      if (pinPulse) runLen++;
      else if (runLen != 0) begin
        if (pinCheckEn) check(runLen == PULSE, "R5", "pinPulse width", runLen, PULSE);
        runLen = 0;
      end
      prevPin = pinPulse;
    end
  end

  task automatic waitUntil(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic expectEvents(input int r, input int p, input int n);
    expQ.delete();
    for (int k = 1; k <= n; k++) expQ.push_back(r + k * p * CPM);
  endtask

  task automatic phaseEnd(input string req);
    check(expQ.size() == 0, req, "expected events left", expQ.size(), 0);
  endtask

  task automatic pulseSw(output int r);
    @(negedge clk);
    swRestart = 1'b1;
    r = cyc + 1;
    @(negedge clk);
    swRestart = 1'b0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    check(1'b0, "R3", "watchdog expired", cyc, 0);
    summary();
  end

  initial begin
    int r;
    int r2;
    int x;
    int ev0;
    // R1: reset state
    repeat (4) @(negedge clk);
    check(irqEvent == 1'b0, "R1", "irqEvent in reset", irqEvent, 0);
    check(pinPulse == 1'b0, "R1", "pinPulse in reset", pinPulse, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(irqEvent == 1'b0 && pinPulse == 1'b0, "R1", "outputs after reset",
          {irqEvent, pinPulse}, 0);

    // R2: zero period produces nothing
    waitUntil(cyc + 400);
    check(evCount == 0, "R2", "events with zero period", evCount, 0);
    check(pinStarts == 0, "R2", "pin pulses with zero period", pinStarts, 0);

    // R3, R9: period set to 3 ms restarts and runs periodically
    @(negedge clk);
    period = 16'd3;
    r = cyc + 1;
    expectEvents(r, 3, 3);
    waitUntil(r + 3 * 3 * CPM + 5);
    phaseEnd("R3");

    // R6: software restart mid-period moves the next timeout
    waitUntil(cyc + 50);
    expQ.delete();
    pulseSw(r2);
    expectEvents(r2, 3, 2);
    waitUntil(r2 + 2 * 3 * CPM + 5);
    phaseEnd("R6");

    // R8: restart on the very edge of a timeout wins
    x = r2 + 3 * 3 * CPM;
    ev0 = evCount;
    waitUntil(x - 1);
    expQ.delete();
    expQ.push_back(x + 3 * CPM);
    swRestart = 1'b1;
    @(negedge clk);
    swRestart = 1'b0;
    waitUntil(x + 3 * CPM + 5);
    check(evCount - ev0 == 1, "R8", "events across same-edge restart", evCount - ev0, 1);
    phaseEnd("R8");

    // R7: hardware restart held high holds the count at zero
    @(negedge clk);
    expQ.delete();
    ev0 = evCount;
    hwRestart = 1'b1;
    waitUntil(cyc + 500);
    hwRestart = 1'b0;
    r = cyc;
    check(evCount == ev0, "R7", "events while hwRestart held", evCount - ev0, 0);
    expectEvents(r, 3, 2);
    waitUntil(r + 2 * 3 * CPM + 5);
    phaseEnd("R7");

    // R9: changing the period between nonzero values restarts
    @(negedge clk);
    period = 16'd2;
    r = cyc + 1;
    expectEvents(r, 2, 3);
    waitUntil(r + 3 * 2 * CPM + 5);
    phaseEnd("R9");

    // R3 boundary: 1 ms period; then R10: cancel to zero mid-pulse
    @(negedge clk);
    period = 16'd1;
    r = cyc + 1;
    expectEvents(r, 1, 2);
    waitUntil(r + 2 * CPM + 10);
    phaseEnd("R3");
    check(pinPulse == 1'b1, "R10", "pinPulse before cancel", pinPulse, 1);
    pinCheckEn = 1'b0;
    period = 16'd0;
    @(negedge clk);
    check(pinPulse == 1'b0, "R10", "pinPulse after cancel", pinPulse, 0);
    ev0 = evCount;
    waitUntil(cyc + 200);
    check(evCount == ev0, "R2", "events after disable", evCount - ev0, 0);
    check(pinPulse == 1'b0, "R2", "pinPulse after disable", pinPulse, 0);
    pinCheckEn = 1'b1;

    summary();
  end
endmodule